// File: doc/BRIEF.md
# Overlay Vertical Scan-Line Sequencer

This block produces the vertical timing of a text overlay that is ten character rows tall, each character cell being sixteen glyph lines high. After a vertical flyback ends, it counts horizontal flyback pulses. Once a programmable start delay has passed, it walks through the character rows and the glyph lines inside each row, and it flags the lines in which the overlay is visible. A downstream glyph fetch and pixel shifter use the row and line outputs to address character data.

A six-bit height code stretches each character cell so that the overlay covers a similar share of the screen in different sync modes. The two upper code bits repeat every glyph line one, two or three extra times. Each of the four lower code bits adds one extra emission to its own evenly spread set of glyph lines. A per-row tall bit then doubles every emission count in that row. Both flyback inputs are asynchronous. They are synchronized to the pixel clock, and the block acts on their falling edges.

Top module: `osd_vline_gen`

## Requirements
- R1: While reset is asserted and right after it, `vact_o` is 0, `row_o` is 0 and `gline_o` is 0.
- R2: After a falling edge of `vfly_i`, `vact_o` rises on the (4*`vstart_i`+1)-th falling edge of `hfly_i`, with `row_o`=0 and `gline_o`=0.
- R3: `hcode_i[5:4]` sets a base emission count for every glyph line. A value of 3 gives 4 emissions, 2 gives 3 emissions, and 0 or 1 gives 2 emissions.
- R4: Each lower code bit adds one emission to a set of glyph lines. Bit 0 adds to line 8. Bit 1 adds to lines 4 and 12. Bit 2 adds to lines 2, 6, 10 and 14. Bit 3 adds to every odd line.
- R5: When bit r of `tall_rows_i` is 1, every glyph line of character row r is emitted twice as many times.
- R6: Each `hfly_i` falling edge while active advances one emission. After the last emission of a line, `gline_o` steps from 0 to 15. After line 15, `gline_o` wraps to 0 and `row_o` steps, for rows 0 to 9.
- R7: After the last emission of line 15 in row 9, `vact_o` clears and `row_o` and `gline_o` return to 0. Further `hfly_i` edges leave them unchanged until the next `vfly_i` falling edge.
- R8: A `vfly_i` falling edge in the middle of a frame clears `vact_o` and `row_o` and `gline_o` at once, and restarts the start delay.
- R9: The outputs change only in the cycle after a synchronized flyback falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hfly_i | input | 1 | Horizontal flyback, asynchronous; each falling edge marks one scan line |
| vfly_i | input | 1 | Vertical flyback, asynchronous; its falling edge starts a frame |
| vstart_i | input | 6 | Start delay code; the delay is 4*code+1 lines |
| hcode_i | input | 6 | Height code (base in bits 5:4, spread weights in bits 3:0) |
| tall_rows_i | input | 10 | Per-row double-height bits, bit r for character row r |
| row_o | output | 4 | Current character row |
| gline_o | output | 4 | Current glyph line inside the row |
| vact_o | output | 1 | Overlay lines are being emitted |

## Verification
Directed frames use a pure base code and single spread bits. These show whether the base count is applied to all lines and whether each spread weight lands on its own lines. Another frame has all spread bits set, which shows whether the weights combine across the sixteen lines. A frame with scattered tall rows shows whether doubling is applied per row and not per frame. Random frames vary delay, code and tall rows at once, and a frame cut short by a new vertical flyback shows that the restart clears the state.

// File: rtl/osd_vl_pkg.sv
package osd_vl_pkg;

   typedef enum logic [1:0] {
      VS_IDLE  = 2'd0,
      VS_DELAY = 2'd1,
      VS_SHOW  = 2'd2
   } vseq_state_t;

   // number of extra emissions selected by the two coarse code bits
   function automatic int unsigned coarse_extra(input logic [1:0] c);
      case (c)
         2'b11:   return 3;
         2'b10:   return 2;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/osd_fly_sync.sv
module osd_fly_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("osd_fly_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~chain_q[STAGES-1];

   // R9: a detected edge lasts exactly one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/osd_vl_weight.sv
module osd_vl_weight #(
   parameter int LINE_W = 4,
   parameter int CODE_W = 6,
   parameter int REP_W  = 4
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              tall_i,
   output logic [REP_W-1:0]  emit_o
);
   import osd_vl_pkg::*;

   if (CODE_W != LINE_W + 2) begin : g_bad_code
      $error("osd_vl_weight: CODE_W must equal LINE_W + 2");
   end

   logic [LINE_W-1:0] sel;

   // weight 2**k picks lines whose low (LINE_W-k) bits equal 2**(LINE_W-k-1)
   for (genvar k = 0; k < LINE_W; k++) begin : g_spread
      localparam int SW = LINE_W - k;
      localparam logic [SW-1:0] PAT = SW'(2 ** (SW - 1));
      assign sel[k] = code_i[k] && (line_i[SW-1:0] == PAT);
   end

   logic [REP_W-1:0] base;
   logic [REP_W-1:0] single;

   always_comb begin
      base   = REP_W'(coarse_extra(code_i[CODE_W-1:CODE_W-2]));
      single = REP_W'(1) + base + REP_W'($countones(sel));
      emit_o = tall_i ? (single << 1) : single;
   end

   // R4: the spread patterns are disjoint, a line takes at most one weight
   always_comb begin
      a_r4_one_weight: assert ($countones(sel) <= 1);
   end

endmodule

// File: rtl/osd_vl_seq.sv
module osd_vl_seq #(
   parameter int ROWS    = 10,
   parameter int LINES   = 16,
   parameter int START_W = 6,
   parameter int REP_W   = 4,
   parameter int ROW_W   = 4,
   parameter int LINE_W  = 4,
   parameter int DLY_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_tick,
   input  logic               frame_start,
   input  logic [START_W-1:0] start_code,
   input  logic [REP_W-1:0]   emit_cnt,
   output logic [ROW_W-1:0]   row_q,
   output logic [LINE_W-1:0]  line_q,
   output logic               active
);
   import osd_vl_pkg::*;

   if (DLY_W != START_W + 2) begin : g_bad_dly
      $error("osd_vl_seq: DLY_W must equal START_W + 2");
   end

   vseq_state_t      st_q;
   logic [DLY_W-1:0] dly_q;
   logic [REP_W-1:0] rep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= VS_IDLE;
         dly_q  <= '0;
         rep_q  <= '0;
         row_q  <= '0;
         line_q <= '0;
      end else if (frame_start) begin
         st_q   <= VS_DELAY;
         dly_q  <= {start_code, 2'b00} + DLY_W'(1);
         rep_q  <= '0;
         row_q  <= '0;
         line_q <= '0;
      end else if (line_tick) begin
         case (st_q)
            VS_DELAY: begin
               dly_q <= dly_q - DLY_W'(1);
               if (dly_q == DLY_W'(1)) st_q <= VS_SHOW;
            end
            VS_SHOW: begin
               if (rep_q + REP_W'(1) == emit_cnt) begin
                  rep_q <= '0;
                  if (line_q == LINE_W'(LINES - 1)) begin
                     line_q <= '0;
                     if (row_q == ROW_W'(ROWS - 1)) begin
                        row_q <= '0;
                        st_q  <= VS_IDLE;
                     end else begin
                        row_q <= row_q + ROW_W'(1);
                     end
                  end else begin
                     line_q <= line_q + LINE_W'(1);
                  end
               end else begin
                  rep_q <= rep_q + REP_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign active = (st_q == VS_SHOW);

   // R2: the active flag rises only on a line edge that ends the delay
   a_r2_rise_at_delay_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> ($past(line_tick) && $past(dly_q) == DLY_W'(1)
                         && row_q == '0 && line_q == '0));

   // R6: a wrap of the glyph line steps the row
   a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && line_q == '0 && $past(line_q) != '0)
      |-> row_q == $past(row_q) + ROW_W'(1));

   // R7: the flag only falls after the last line of the last row, or on restart
   a_r7_end_of_frame: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(active) && !$past(frame_start))
      |-> ($past(row_q) == ROW_W'(ROWS - 1) && $past(line_q) == LINE_W'(LINES - 1)));

   // R7: once finished, the sequencer waits for a new frame
   a_r7_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == VS_IDLE && !frame_start) |=> st_q == VS_IDLE);

   // R8: a frame start clears the visible state in the next cycle
   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (!active && row_q == '0 && line_q == '0));

   // R9: without an edge the outputs hold
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_tick && !frame_start) |=> $stable({active, row_q, line_q}));

endmodule

// File: rtl/osd_vline_gen.sv
module osd_vline_gen #(
   parameter int ROWS        = 10,
   parameter int LINES       = 16,
   parameter int START_W     = 6,
   parameter int CODE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hfly_i,
   input  logic                       vfly_i,
   input  logic [START_W-1:0]         vstart_i,
   input  logic [CODE_W-1:0]          hcode_i,
   input  logic [ROWS-1:0]            tall_rows_i,
   output logic [$clog2(ROWS)-1:0]    row_o,
   output logic [$clog2(LINES)-1:0]   gline_o,
   output logic                       vact_o
);

   localparam int ROW_W    = $clog2(ROWS);
   localparam int LINE_W   = $clog2(LINES);
   localparam int DLY_W    = START_W + 2;
   localparam int MAX_EMIT = (1 + 3 + 1) * 2;
   localparam int REP_W    = $clog2(MAX_EMIT + 1);

   if ((1 << LINE_W) != LINES) begin : g_bad_lines
      $error("osd_vline_gen: LINES must be a power of two");
   end
   if (CODE_W != LINE_W + 2) begin : g_bad_code
      $error("osd_vline_gen: CODE_W must equal log2(LINES) + 2");
   end

   logic             h_fall;
   logic             v_fall;
   logic [REP_W-1:0] emit_cnt;
   logic             row_tall;

   osd_fly_sync #(.STAGES(SYNC_STAGES)) u_hsync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (hfly_i),
      .fall_o(h_fall)
   );

   osd_fly_sync #(.STAGES(SYNC_STAGES)) u_vsync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (vfly_i),
      .fall_o(v_fall)
   );

   assign row_tall = tall_rows_i[row_o];

   osd_vl_weight #(
      .LINE_W(LINE_W),
      .CODE_W(CODE_W),
      .REP_W (REP_W)
   ) u_weight (
      .line_i(gline_o),
      .code_i(hcode_i),
      .tall_i(row_tall),
      .emit_o(emit_cnt)
   );

   osd_vl_seq #(
      .ROWS   (ROWS),
      .LINES  (LINES),
      .START_W(START_W),
      .REP_W  (REP_W),
      .ROW_W  (ROW_W),
      .LINE_W (LINE_W),
      .DLY_W  (DLY_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_tick  (h_fall),
      .frame_start(v_fall),
      .start_code (vstart_i),
      .emit_cnt   (emit_cnt),
      .row_q      (row_o),
      .line_q     (gline_o),
      .active     (vact_o)
   );

   // R5: a tall row always has an even emission count
   a_r5_tall_even: assert property (@(posedge clk) disable iff (!rst_n)
      (vact_o && row_tall) |-> !emit_cnt[0]);

   // R3: every line is emitted at least twice
   a_r3_min_emit: assert property (@(posedge clk) disable iff (!rst_n)
      vact_o |-> emit_cnt >= REP_W'(2));

endmodule

// File: tb/sim_osd_vline_gen.sv
module sim_osd_vline_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hfly = 1'b0;
   logic       vfly = 1'b0;
   logic [5:0] vstart = '0;
   logic [5:0] hcode = '0;
   logic [9:0] tall = '0;
   logic [3:0] row;
   logic [3:0] gline;
   logic       vact;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   osd_vline_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .hfly_i     (hfly),
      .vfly_i     (vfly),
      .vstart_i   (vstart),
      .hcode_i    (hcode),
      .tall_rows_i(tall),
      .row_o      (row),
      .gline_o    (gline),
      .vact_o     (vact)
   );

   // bench model state
   int m_st, m_dly, m_row, m_line, m_rep;

   function automatic int emits(input int ln, input logic [5:0] c, input logic t);
      int n;
      n = 1 + ((c[5:4] == 2'b11) ? 3 : (c[5:4] == 2'b10) ? 2 : 1);
      if ((c[0] && ln == 8) || (c[1] && (ln == 4 || ln == 12)) ||
          (c[2] && (ln % 4 == 2)) || (c[3] && (ln % 2 == 1)))
         n = n + 1;
      return t ? 2 * n : n;
   endfunction

   function automatic int frame_height(input logic [5:0] c, input logic [9:0] t);
      int s = 0;
      for (int r = 0; r < 10; r++)
         for (int l = 0; l < 16; l++)
            s += emits(l, c, t[r]);
      return s;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int pack_out(input int a, input int r, input int l);
      return a * 256 + r * 16 + l;
   endfunction

   task automatic vpulse();
      vfly = 1'b1;
      repeat (3) @(negedge clk);
      vfly = 1'b0;
      m_st = 1; m_dly = 4 * vstart + 1; m_row = 0; m_line = 0; m_rep = 0;
      repeat (6) @(negedge clk);
   endtask

   task automatic hpulse();
      int n;
      hfly = 1'b1;
      repeat (2) @(negedge clk);
      hfly = 1'b0;
      if (m_st == 1) begin
         m_dly--;
         if (m_dly == 0) m_st = 2;
      end else if (m_st == 2) begin
         n = emits(m_line, hcode, tall[m_row]);
         if (m_rep + 1 == n) begin
            m_rep = 0;
            if (m_line == 15) begin
               m_line = 0;
               if (m_row == 9) begin m_row = 0; m_st = 0; end
               else m_row++;
            end else m_line++;
         end else m_rep++;
      end
      repeat (6) @(negedge clk);
   endtask

   // runs one frame; stops early after max_ticks line pulses
   task automatic run_frame(input string tag, input int max_ticks);
      int ticks = 0, rise_at = -1, act_n = 0, mism = 0;
      int got, exp;
      vpulse();
      check({tag, " R8 frame start clears"}, pack_out(vact, row, gline), 0);
      while (ticks < max_ticks) begin
         hpulse();
         ticks++;
         got = pack_out(vact, row, gline);
         exp = pack_out(m_st == 2, m_row, m_line);
         if (got != exp && mism < 3) begin
            mism++;
            check({tag, " R6 sequence step"}, got, exp);
         end
         if (vact) begin
            act_n++;
            if (rise_at < 0) rise_at = ticks;
         end
         if (m_st == 0) break;
      end
      if (mism == 0) check({tag, " R6 sequence matches"}, 1, 1);
      if (ticks < max_ticks) begin
         check({tag, " R2 start delay"}, rise_at, 4 * vstart + 1);
         check({tag, " R3 R4 R5 frame height"}, act_n, frame_height(hcode, tall));
         for (int i = 0; i < 3; i++) begin
            hpulse();
            check({tag, " R7 idle after frame"}, pack_out(vact, row, gline), 0);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", pack_out(vact, row, gline), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after reset", pack_out(vact, row, gline), 0);
      // R9: line pulses before any frame start change nothing
      hpulse();
      check("R9 no frame yet", pack_out(vact, row, gline), 0);

      // R3 base code 00
      vstart = 6'd0; hcode = 6'b000000; tall = '0;
      run_frame("base00", 100000);
      // R3 base code 11
      vstart = 6'd3; hcode = 6'b110000;
      run_frame("base11", 100000);
      // R4 bit 0 with base 10
      vstart = 6'd1; hcode = 6'b100001;
      run_frame("bit0", 100000);
      // R4 all spread bits
      vstart = 6'd2; hcode = 6'b001111;
      run_frame("spread", 100000);
      // R5 scattered tall rows with bit 2
      vstart = 6'd0; hcode = 6'b010100; tall = 10'b1000000101;
      run_frame("tall", 100000);
      // R8 restart in mid frame, then a full frame
      vstart = 6'd1; hcode = 6'b100010; tall = 10'b0000110000;
      run_frame("cut", 60);
      run_frame("after_cut", 100000);

      void'($urandom(32'd2024));
      for (int f = 0; f < 3; f++) begin
         vstart = 6'($urandom % 64);
         hcode  = 6'($urandom);
         tall   = 10'($urandom);
         run_frame("random", 100000);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule